// File: doc/BRIEF.md
# Same-Cycle Fixed-Priority Shared Memory Arbiter

This block lets several processor masters share one memory controller over a simple point-to-point synchronous interconnect. Each master sees what looks like a private memory slave, and the memory controller sees what looks like a single master. Each strobe (read or write), with its address and write data, lasts one clock cycle. The memory controller reports its progress through a 2-bit ready-count. The arbiter chooses a winner in the cycle a request arrives and forwards it to the memory port combinationally, so an access that meets no contention adds no cycles.

A request that loses to a lower-indexed master, or that arrives while the memory is busy, is stored in a per-master pending slot. The master therefore never has to hold its strobe. Stored requests go out on the first cycle the memory reports ready, again in index order. Read data and the ready-count are steered back only to the master that owns the transaction in flight. The arbiter adds no bus-request phase, and neither side can tell that arbitration takes place.

Top module: `shared_mem_arbiter`

## Requirements
- R1: After synchronous reset, no request is pending and no master owns the memory: every master ready-count is 0, and no strobe reaches the memory port until a master raises one.
- R2: When the memory ready-count is 0, a strobe from a single master reaches the memory port in the same cycle. The read or write strobe, the address and the write data are all passed through. When no request is forwarded, the memory strobes, address and write data are 0.
- R3: When several masters strobe in a cycle where the memory ready-count is 0, the master with the lowest index is forwarded in that same cycle.
- R4: A strobe that loses, or that arrives while the memory ready-count is nonzero, is captured with its address, write data and direction. It is later issued with those captured values, even if the master's lines have changed since.
- R5: When several requests are pending, or pending and new requests compete, the one with the lowest master index is issued first.
- R6: Nothing is forwarded to the memory port in a cycle where the memory ready-count is nonzero.
- R7: A master with a pending request sees ready-count 3 on its own port. The exception is a cycle in which it owns the current transaction and the memory reports 0; in that cycle it sees 0.
- R8: The master that owns the last issued transaction sees the memory ready-count unchanged. A master that neither owns the transaction nor has a pending request sees 0.
- R9: Memory read data appears only on the read-data port of the owning master. Every other master's read data is 0.
- R10: The ready-count is 2 bits wide. 0 means the data is valid in this cycle and the port can take a new command. 3 means busy with no known completion time. 1 and 2 count the remaining cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_addr | input | N x AW | Per-master address, valid with a strobe |
| m_wdata | input | N x DW | Per-master write data, valid with a write strobe |
| m_rd | input | N | Per-master one-cycle read strobe |
| m_wr | input | N | Per-master one-cycle write strobe |
| m_rdata | output | N x DW | Per-master read data (owner only) |
| m_rdy_cnt | output | N x 2 | Per-master ready-count |
| s_addr | output | AW | Address to memory controller |
| s_wdata | output | DW | Write data to memory controller |
| s_rd | output | 1 | Read strobe to memory controller |
| s_wr | output | 1 | Write strobe to memory controller |
| s_rdata | input | DW | Read data from memory controller |
| s_rdy_cnt | input | 2 | Ready-count from memory controller |

## Verification
The memory strobe, address and write data are due in the same cycle as the winning strobe, or in the first cycle the memory ready-count is 0 for a stored request. The bench drives each cycle's strobes just after the falling edge and samples the memory port one time unit later, before the next rising edge. A master's ready-count reflects pending state and ownership one rising edge after the strobe is taken. The bench model shows 1 on the next cycle and returns read data two cycles after issue. The cycle table lists the expected values cycle by cycle at exactly those offsets, and the read-data checks run on the row where the model reports 0.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
  localparam int RDY_W = 2;
  // ready-count codes
  localparam logic [RDY_W-1:0] RDY_DONE = 2'd0;  // data valid, port free
  localparam logic [RDY_W-1:0] RDY_BUSY = 2'd3;  // busy, completion unknown
endpackage

// File: rtl/arb_prio_pick.sv
`timescale 1ns/1ps
// Lowest index wins; one-hot and binary forms of the winner.
module arb_prio_pick #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [N-1:0]     onehot,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found  = |req;
    onehot = '0;
    idx    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        onehot    = '0;
        onehot[i] = 1'b1;
        idx       = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/arb_hold_slot.sv
`timescale 1ns/1ps
// One-entry holding register for a strobe that could not be forwarded.
module arb_hold_slot #(
  parameter int AW = 21,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic          clr,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic          in_rd,
  input  logic          in_wr,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          rd,
  output logic          wr
);
  always_ff @(posedge clk) begin
    if (rst)      valid <= 1'b0;
    else if (clr) valid <= 1'b0;
    else if (cap) valid <= 1'b1;
  end

  // payload needs no reset: qualified by valid
  always_ff @(posedge clk) begin
    if (cap) begin
      addr  <= in_addr;
      wdata <= in_wdata;
      rd    <= in_rd;
      wr    <= in_wr;
    end
  end
endmodule

// File: rtl/shared_mem_arbiter.sv
`timescale 1ns/1ps
module shared_mem_arbiter
  import arb_pkg::*;
#(
  parameter int N  = 3,
  parameter int AW = 21,
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N-1:0][AW-1:0]      m_addr,
  input  logic [N-1:0][DW-1:0]      m_wdata,
  input  logic [N-1:0]              m_rd,
  input  logic [N-1:0]              m_wr,
  output logic [N-1:0][DW-1:0]      m_rdata,
  output logic [N-1:0][RDY_W-1:0]   m_rdy_cnt,
  output logic [AW-1:0]             s_addr,
  output logic [DW-1:0]             s_wdata,
  output logic                      s_rd,
  output logic                      s_wr,
  input  logic [DW-1:0]             s_rdata,
  input  logic [RDY_W-1:0]          s_rdy_cnt
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]          live_req, cand, pick_oh;
  logic [N-1:0]          pend_v, pend_rd, pend_wr, cap, clr;
  logic [N-1:0][AW-1:0]  pend_addr;
  logic [N-1:0][DW-1:0]  pend_wdata;
  logic                  found, mem_free, grant, own_v;
  logic [IDX_W-1:0]      win_idx, own_idx;

  assign live_req = m_rd | m_wr;
  assign cand     = live_req | pend_v;
  assign mem_free = (s_rdy_cnt == RDY_DONE);
  assign grant    = mem_free & found;

  arb_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .req(cand), .found(found), .onehot(pick_oh), .idx(win_idx)
  );

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign clr[g] = grant & pick_oh[g];
    assign cap[g] = live_req[g] & ~pend_v[g] & ~(grant & pick_oh[g]);

    arb_hold_slot #(.AW(AW), .DW(DW)) u_slot (
      .clk(clk), .rst(rst), .cap(cap[g]), .clr(clr[g]),
      .in_addr(m_addr[g]), .in_wdata(m_wdata[g]),
      .in_rd(m_rd[g]), .in_wr(m_wr[g]),
      .valid(pend_v[g]), .addr(pend_addr[g]), .wdata(pend_wdata[g]),
      .rd(pend_rd[g]), .wr(pend_wr[g])
    );
  end

  // forward the winner, stored copy taking precedence over live lines
  always_comb begin
    s_addr  = '0;
    s_wdata = '0;
    s_rd    = 1'b0;
    s_wr    = 1'b0;
    if (grant) begin
      for (int i = 0; i < N; i++) begin
        if (pick_oh[i]) begin
          if (pend_v[i]) begin
            s_addr  = pend_addr[i];
            s_wdata = pend_wdata[i];
            s_rd    = pend_rd[i];
            s_wr    = pend_wr[i];
          end else begin
            s_addr  = m_addr[i];
            s_wdata = m_wdata[i];
            s_rd    = m_rd[i];
            s_wr    = m_wr[i];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_v   <= 1'b0;
      own_idx <= '0;
    end else if (grant) begin
      own_v   <= 1'b1;
      own_idx <= win_idx;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_ret
    logic is_own;
    assign is_own     = own_v && (own_idx == IDX_W'(g));
    assign m_rdata[g] = is_own ? s_rdata : '0;
    always_comb begin
      if (is_own && mem_free) m_rdy_cnt[g] = RDY_DONE;
      else if (pend_v[g])     m_rdy_cnt[g] = RDY_BUSY;
      else if (is_own)        m_rdy_cnt[g] = s_rdy_cnt;
      else                    m_rdy_cnt[g] = RDY_DONE;
    end
  end
endmodule

// File: rtl/shared_mem_arbiter_chk.sv
`timescale 1ns/1ps
module shared_mem_arbiter_chk #(
  parameter int N  = 3,
  parameter int AW = 21,
  parameter int DW = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N-1:0][AW-1:0] m_addr,
  input logic [N-1:0]         m_rd,
  input logic [N-1:0]         m_wr,
  input logic [N-1:0][DW-1:0] m_rdata,
  input logic [N-1:0][1:0]    m_rdy_cnt,
  input logic [AW-1:0]        s_addr,
  input logic                 s_rd,
  input logic                 s_wr,
  input logic [1:0]           s_rdy_cnt
);
  logic [N-1:0] req, data_nz;
  assign req = m_rd | m_wr;
  for (genvar g = 0; g < N; g++) begin : g_nz
    assign data_nz[g] = |m_rdata[g];
  end

  p_single_dir_r2: assert property (@(posedge clk) disable iff (rst)
    !(s_rd && s_wr));

  p_no_issue_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (s_rdy_cnt != 2'd0) |-> !(s_rd || s_wr));

  // R3: the top-priority master always passes straight through when free
  p_top_zero_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (req[0] && s_rdy_cnt == 2'd0) |-> ((s_rd || s_wr) && s_addr == m_addr[0]));

  p_owner_only_data_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(data_nz));

  for (genvar g = 1; g < N; g++) begin : g_lose
    logic lower;
    assign lower = |req[g-1:0];
    p_loser_busy_r7: assert property (@(posedge clk) disable iff (rst)
      (req[g] && lower && s_rdy_cnt == 2'd0) |=> (m_rdy_cnt[g] == 2'd3));
  end
endmodule

bind shared_mem_arbiter shared_mem_arbiter_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/shared_mem_arbiter_bench.sv
`timescale 1ns/1ps
// Two-cycle SRAM controller model: ready 1 the cycle after a command, 0 with data the next.
module bench_sram #(
  parameter int AW = 21,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  input  logic          wr,
  output logic [DW-1:0] rdata,
  output logic [1:0]    rdy_cnt
);
  logic [DW-1:0] mem [64];
  logic [5:0]    h_addr;
  logic [DW-1:0] h_wdata;
  logic          h_wr;
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_cnt <= 2'd0;
      rdata   <= '0;
      h_addr  <= '0;
      h_wdata <= '0;
      h_wr    <= 1'b0;
      for (int k = 0; k < 64; k++) mem[k] <= 32'hA000_0000 + k;
    end else if (rd || wr) begin
      h_addr  <= addr[5:0];
      h_wdata <= wdata;
      h_wr    <= wr;
      rdy_cnt <= 2'd1;
    end else if (rdy_cnt == 2'd1) begin
      rdy_cnt <= 2'd0;
      if (h_wr) mem[h_addr] <= h_wdata;
      else      rdata <= mem[h_addr];
    end
  end
endmodule

module shared_mem_arbiter_bench;
  localparam int N = 3, AW = 21, DW = 32, ROWS = 21;
  // row: [15:13] rd mask, [12:10] wr mask, [9] s_rd, [8] s_wr,
  //      [7:6] s_addr, [5:0] ready-counts {m2,m1,m0}
  localparam logic [15:0] VEC [ROWS] = '{
    16'h0000, 16'h4280, 16'h0004, 16'h0000, 16'h3240, 16'h0031, 16'h01F0,
    16'h0010, 16'h4540, 16'h800D, 16'h02BC, 16'h0034, 16'h02F0, 16'h0010,
    16'hC280, 16'h2034, 16'h0273, 16'h0031, 16'h02F0, 16'h0010, 16'h0000};

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0][AW-1:0] m_addr;
  logic [N-1:0][DW-1:0] m_wdata, m_rdata;
  logic [N-1:0]         m_rd, m_wr;
  logic [N-1:0][1:0]    m_rdy_cnt;
  logic [AW-1:0]        s_addr;
  logic [DW-1:0]        s_wdata, s_rdata;
  logic                 s_rd, s_wr;
  logic [1:0]           s_rdy_cnt;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  shared_mem_arbiter #(.N(N), .AW(AW), .DW(DW)) u_shared_mem_arbiter (
    .clk(clk), .rst(rst), .m_addr(m_addr), .m_wdata(m_wdata), .m_rd(m_rd),
    .m_wr(m_wr), .m_rdata(m_rdata), .m_rdy_cnt(m_rdy_cnt), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_rd(s_rd), .s_wr(s_wr), .s_rdata(s_rdata),
    .s_rdy_cnt(s_rdy_cnt));

  bench_sram #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst(rst), .addr(s_addr), .wdata(s_wdata), .rd(s_rd),
    .wr(s_wr), .rdata(s_rdata), .rdy_cnt(s_rdy_cnt));

  task automatic chk(input bit ok, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // strobing masters show their own address/data; idle ones show junk
  task automatic drive(input logic [2:0] rd, input logic [2:0] wr);
    for (int i = 0; i < N; i++) begin
      m_rd[i] = rd[i];
      m_wr[i] = wr[i];
      if (rd[i] || wr[i]) begin
        m_addr[i]  = AW'(i + 1);
        m_wdata[i] = 32'h5500_0000 + i;
      end else begin
        m_addr[i]  = AW'(6'h3F);
        m_wdata[i] = 32'hDEAD_BEEF;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    drive(3'b000, 3'b000);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state
    chk(m_rdy_cnt == '0, "R1 ready-counts after reset", 64'(m_rdy_cnt), 64'h0);
    chk(!s_rd && !s_wr, "R1 no strobe after reset", 64'({s_rd, s_wr}), 64'h0);

    for (int r = 0; r < ROWS; r++) begin
      logic [15:0] v;
      @(negedge clk);
      v = VEC[r];
      drive(v[15:13], v[12:10]);
      #1;
      chk(s_rd == v[9], $sformatf("R2 R3 R4 R5 R6 s_rd row %0d", r), 64'(s_rd), 64'(v[9]));
      chk(s_wr == v[8], $sformatf("R2 R4 R6 s_wr row %0d", r), 64'(s_wr), 64'(v[8]));
      chk(s_addr == AW'(v[7:6]), $sformatf("R2 R3 R5 s_addr row %0d", r),
          64'(s_addr), 64'(v[7:6]));
      chk(m_rdy_cnt == v[5:0], $sformatf("R7 R8 R10 ready row %0d", r),
          64'(m_rdy_cnt), 64'(v[5:0]));
      if (r == 6)  chk(s_wdata == 32'h5500_0002, "R4 stored write data", 64'(s_wdata), 64'h55000002);
      if (r == 8)  chk(s_wdata == 32'h5500_0000, "R2 live write data", 64'(s_wdata), 64'h55000000);
      if (r == 3) begin
        chk(m_rdata[1] == 32'hA000_0002, "R9 owner read data", 64'(m_rdata[1]), 64'hA0000002);
        chk(m_rdata[0] == '0 && m_rdata[2] == '0, "R9 non-owner zero",
            64'({m_rdata[0], m_rdata[2]}), 64'h0);
      end
      if (r == 18) chk(m_rdata[0] == 32'h5500_0000, "R9 owner reads written word",
                       64'(m_rdata[0]), 64'h55000000);
      if (r == 20) begin
        chk(m_rdata[2] == 32'h5500_0002, "R4 R9 pending write landed",
            64'(m_rdata[2]), 64'h55000002);
        chk(m_rdata[0] == '0 && m_rdata[1] == '0, "R9 others zero",
            64'({m_rdata[0], m_rdata[1]}), 64'h0);
      end
    end

    // R1: reset discards a stored request
    @(negedge clk) drive(3'b001, 3'b000);
    @(negedge clk) drive(3'b010, 3'b000);
    #1 chk(!s_rd, "R6 busy blocks master1", 64'(s_rd), 64'h0);
    @(negedge clk) begin drive(3'b000, 3'b000); rst = 1'b1; end
    @(negedge clk) rst = 1'b0;
    #1;
    chk(!s_rd && !s_wr, "R1 pending cleared by reset", 64'({s_rd, s_wr}), 64'h0);
    chk(m_rdy_cnt == '0, "R1 R8 ready idle after reset", 64'(m_rdy_cnt), 64'h0);

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule